// File: doc/BRIEF.md
# Half-Page NAND Read Sequencer

This block runs a multi-page read from a small-page NAND device whose array is accessed in 256-byte halves. The page size is 256 or 512 bytes, chosen per transfer. From a byte start address and a byte length it works out the start page, the starting half and the column. It then hands one read command per 256-byte chunk to a downstream command sequencer, which drives the flash pins, and passes the returned bytes on to an output stream. On 512-byte pages it alternates between first-half and second-half reads and moves to the next page only after a second half. Only the first chunk starts at a non-zero column.

In ECC mode each chunk is read in full from column 0, and only the requested window is forwarded. The block then reads the three stored check bytes for that half from the spare area and issues a first-half read to put the device pointer back. It presents the check bytes to an external checker, which answers in the same cycle. An uncorrectable answer ends the transfer with an error. A request that runs past the end of the device is refused before any command is issued.

Top module: `nand_half_reader`

## Requirements
- R1: If start address plus length exceeds 2^DEV_LOG2 bytes, `done_o` and `err_o` pulse together one cycle after `start_i` and no command is issued. A range ending exactly at the device end is accepted.
- R2: The first command's page is the address shifted right by 8 (256-byte pages, `big_page_i`=0) or by 9 (512-byte pages, `big_page_i`=1).
- R3: Command op codes are: 0 = first-half read, 1 = second-half read, 2 = spare read. On 512-byte pages the start half is 1 when address bit 8 is set. The first data command's column is the address modulo 256, and half h uses op h. On 256-byte pages op 1 is never used.
- R4: Every data command after the first carries column 0.
- R5: On 256-byte pages the page increments after each chunk. On 512-byte pages the half toggles after each chunk and the page increments only after a half-1 chunk.
- R6: Each chunk delivers exactly min(256 − column, remaining) bytes on `out_data_o`, in address order. Without ECC, `cmd_len_o` equals that count.
- R7: In ECC mode each data command uses column 0 and length 256. It is followed by a spare read (op 2, column 0 for half 0 or 3 for half 1, length 3) and then an op 0, column 0, length 0 command. `ecc_code_o` then holds the three spare bytes, the first received in bits 23:16.
- R8: `ecc_bad_i` high while `ecc_valid_o` is high aborts the transfer. The next cycle shows `done_o` and `err_o` high and `ce_o` low, and no further command follows.
- R9: `done_o` pulses once the remaining length reaches zero; a zero length completes with no command. `busy_o` is low while `done_o` is high.
- R10: `ce_o` (active-high chip select) is high from acceptance until completion, is high whenever `cmd_valid_o` is high, and is low after reset and in the `done_o` cycle.
- R11: `start_i` and the mode inputs are ignored while `busy_o` is high.
- R12: A command that is not accepted (`cmd_ready_i` low) stays valid with unchanged op, column, page and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a transfer (sampled when idle) |
| addr_i | input | ADDR_W | Byte start address |
| len_i | input | LEN_W | Byte count |
| big_page_i | input | 1 | 1 = 512-byte pages, 0 = 256-byte pages |
| ecc_mode_i | input | 1 | 1 = fetch and check stored ECC bytes |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | With `done_o`: range reject or ECC abort |
| ce_o | output | 1 | Device select, active high |
| cmd_valid_o | output | 1 | Command request |
| cmd_ready_i | input | 1 | Command accepted |
| cmd_op_o | output | 2 | 0 first-half read, 1 second-half read, 2 spare read |
| cmd_col_o | output | 8 | Column within the half or spare area |
| cmd_page_o | output | ADDR_W-8 | Page number |
| cmd_len_o | output | 9 | Bytes the sequencer should return |
| rd_valid_i | input | 1 | Returned byte valid |
| rd_data_i | input | 8 | Returned byte |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| ecc_valid_o | output | 1 | Stored check bytes presented |
| ecc_code_o | output | 24 | Stored check bytes, first byte in 23:16 |
| ecc_bad_i | input | 1 | Checker reports uncorrectable (same cycle) |

## Verification
Two events can fall in the same cycle: completion of one transfer and the start of the next. The bench runs every transfer back to back, raising `start_i` in the very cycle `done_o` is seen. Each following transfer must then produce exactly its own command sequence and byte stream. The second overlap is a stray `start_i`, with changed mode inputs, arriving mid-transfer; it must leave every command and byte of the running transfer unchanged. Commands and bytes are judged against an address walk and a byte-value formula that are computed in the bench.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
  localparam int HALF_BYTES = 256;
  localparam int ECC_BYTES  = 3;

  typedef enum logic [1:0] {
    OP_RD_LO = 2'd0,
    OP_RD_HI = 2'd1,
    OP_SPARE = 2'd2
  } nrs_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_DATA, S_SP_CMD, S_SP_DATA, S_RST_CMD, S_CHECK, S_ADV
  } nrs_state_e;
endpackage

// File: rtl/nrs_start_split.sv
module nrs_start_split #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = ADDR_W - 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              big_i,
  output logic [PAGE_W-1:0] page_o,
  output logic              half_o,
  output logic [7:0]        col_o
);
  always_comb begin
    if (big_i) page_o = {1'b0, addr_i[ADDR_W-1:9]};
    else       page_o = addr_i[ADDR_W-1:8];
    // upper-half column loses 256 by dropping bit 8
    half_o = big_i & addr_i[8];
    col_o  = addr_i[7:0];
  end
endmodule

// File: rtl/nrs_step.sv
module nrs_step #(
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 17
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic              half_i,
  input  logic              big_i,
  input  logic [7:0]        col_i,
  input  logic [LEN_W-1:0]  rem_i,
  output logic [8:0]        n_o,
  output logic [PAGE_W-1:0] page_nx_o,
  output logic              half_nx_o
);
  logic [8:0] room;

  always_comb begin
    room = 9'd256 - {1'b0, col_i};
    if (rem_i < LEN_W'(room)) n_o = rem_i[8:0];
    else                      n_o = room;
    page_nx_o = page_i + PAGE_W'(!big_i || half_i);
    half_nx_o = big_i & ~half_i;
  end
endmodule

// File: rtl/nand_half_reader.sv
module nand_half_reader
  import nrs_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LEN_W    = 17,
  parameter int DEV_LOG2 = 16,
  parameter int PAGE_W   = ADDR_W - 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              big_page_i,
  input  logic              ecc_mode_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              ce_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic [7:0]        cmd_col_o,
  output logic [PAGE_W-1:0] cmd_page_o,
  output logic [8:0]        cmd_len_o,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_data_i,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  output logic              ecc_valid_o,
  output logic [23:0]       ecc_code_o,
  input  logic              ecc_bad_i
);
  localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;
  localparam logic [SUM_W-1:0] DEV_BYTES = SUM_W'(1) << DEV_LOG2;

  nrs_state_e        state_q;
  logic [PAGE_W-1:0] page_q, sp_page, page_nx;
  logic              half_q, sp_half, half_nx;
  logic [7:0]        col_q, sp_col;
  logic [LEN_W-1:0]  rem_q;
  logic              big_q, ecc_q, first_q, ce_q, done_q, err_q;
  logic [8:0]        idx_q, n, data_len;
  logic [1:0]        spcnt_q;
  logic [23:0]       code_q;
  logic              out_valid_q;
  logic [7:0]        out_data_q;
  logic [SUM_W-1:0]  end_addr;
  logic              oor, in_win;
  logic [9:0]        win_hi;

  nrs_start_split #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_split (
    .addr_i(addr_i), .big_i(big_page_i),
    .page_o(sp_page), .half_o(sp_half), .col_o(sp_col)
  );

  nrs_step #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_step (
    .page_i(page_q), .half_i(half_q), .big_i(big_q), .col_i(col_q), .rem_i(rem_q),
    .n_o(n), .page_nx_o(page_nx), .half_nx_o(half_nx)
  );

  assign end_addr = SUM_W'(addr_i) + SUM_W'(len_i);
  assign oor      = end_addr > DEV_BYTES;
  assign data_len = ecc_q ? 9'(HALF_BYTES) : n;
  assign win_hi   = {2'b0, col_q} + {1'b0, n};
  // ECC mode reads the whole half; forward only the requested window
  assign in_win   = !ecc_q || (({1'b0, idx_q} >= {2'b0, col_q}) && ({1'b0, idx_q} < win_hi));

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_op_o    = OP_RD_LO;
    cmd_col_o   = '0;
    cmd_len_o   = '0;
    unique case (state_q)
      S_CMD: begin
        cmd_valid_o = 1'b1;
        cmd_op_o    = half_q ? OP_RD_HI : OP_RD_LO;
        cmd_col_o   = ecc_q ? 8'd0 : col_q;
        cmd_len_o   = data_len;
      end
      S_SP_CMD: begin
        cmd_valid_o = 1'b1;
        cmd_op_o    = OP_SPARE;
        cmd_col_o   = half_q ? 8'(ECC_BYTES) : 8'd0;
        cmd_len_o   = 9'(ECC_BYTES);
      end
      S_RST_CMD: cmd_valid_o = 1'b1;
      default: ;
    endcase
  end

  assign cmd_page_o  = page_q;
  assign busy_o      = state_q != S_IDLE;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign ce_o        = ce_q;
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign ecc_valid_o = state_q == S_CHECK;
  assign ecc_code_o  = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      page_q      <= '0;
      half_q      <= 1'b0;
      col_q       <= '0;
      rem_q       <= '0;
      big_q       <= 1'b0;
      ecc_q       <= 1'b0;
      first_q     <= 1'b0;
      ce_q        <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      idx_q       <= '0;
      spcnt_q     <= '0;
      code_q      <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      out_valid_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          if (oor) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else if (len_i == '0) begin
            done_q <= 1'b1;
          end else begin
            page_q  <= sp_page;
            half_q  <= sp_half;
            col_q   <= sp_col;
            rem_q   <= len_i;
            big_q   <= big_page_i;
            ecc_q   <= ecc_mode_i;
            first_q <= 1'b1;
            ce_q    <= 1'b1;
            state_q <= S_CMD;
          end
        end
        S_CMD: if (cmd_ready_i) begin
          idx_q   <= '0;
          state_q <= S_DATA;
        end
        S_DATA: if (rd_valid_i) begin
          out_valid_q <= in_win;
          out_data_q  <= rd_data_i;
          idx_q       <= idx_q + 9'd1;
          if (idx_q == data_len - 9'd1) state_q <= ecc_q ? S_SP_CMD : S_ADV;
        end
        S_SP_CMD: if (cmd_ready_i) begin
          spcnt_q <= '0;
          state_q <= S_SP_DATA;
        end
        S_SP_DATA: if (rd_valid_i) begin
          code_q  <= {code_q[15:0], rd_data_i};
          spcnt_q <= spcnt_q + 2'd1;
          if (spcnt_q == 2'(ECC_BYTES - 1)) state_q <= S_RST_CMD;
        end
        S_RST_CMD: if (cmd_ready_i) state_q <= S_CHECK;
        S_CHECK: begin
          if (ecc_bad_i) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            ce_q    <= 1'b0;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_ADV;
          end
        end
        S_ADV: begin
          rem_q   <= rem_q - LEN_W'(n);
          col_q   <= '0;
          first_q <= 1'b0;
          page_q  <= page_nx;
          half_q  <= half_nx;
          if (rem_q == LEN_W'(n)) begin
            done_q  <= 1'b1;
            ce_q    <= 1'b0;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_CMD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_reject_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i && oor) |=> (err_o && done_o && !cmd_valid_o));

  assert_small_page_no_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !big_q) |-> (cmd_op_o != OP_RD_HI));

  assert_later_col_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CMD && !first_q) |-> (cmd_col_o == 8'd0));

  assert_page_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ADV && !big_q) |=> (page_q == $past(page_q) + PAGE_W'(1)));

  assert_ecc_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecc_valid_o && ecc_bad_i) |=> (err_o && done_o && !ce_o && !busy_o));

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !ce_o));

  assert_cmd_selected_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> ce_o);

  assert_cmd_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_col_o)
                                       && $stable(cmd_page_o) && $stable(cmd_len_o)));
endmodule

// File: tb/nand_half_reader_test.sv
`timescale 1ns/1ps
module nand_half_reader_test;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 13;
  localparam int DEV_LOG2 = 12;
  localparam int PAGE_W = ADDR_W - 8;
  localparam int DEV = 1 << DEV_LOG2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [LEN_W-1:0]  len_i = '0;
  logic              big_page_i = 1'b0, ecc_mode_i = 1'b0;
  logic              busy_o, done_o, err_o, ce_o;
  logic              cmd_valid_o, cmd_ready_i = 1'b0;
  logic [1:0]        cmd_op_o;
  logic [7:0]        cmd_col_o;
  logic [PAGE_W-1:0] cmd_page_o;
  logic [8:0]        cmd_len_o;
  logic              rd_valid_i = 1'b0;
  logic [7:0]        rd_data_i = '0;
  logic              out_valid_o;
  logic [7:0]        out_data_o;
  logic              ecc_valid_o;
  logic [23:0]       ecc_code_o;
  logic              ecc_bad_i = 1'b0;

  nand_half_reader #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEV_LOG2(DEV_LOG2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i), .len_i(len_i),
    .big_page_i(big_page_i), .ecc_mode_i(ecc_mode_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .ce_o(ce_o), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_op_o(cmd_op_o), .cmd_col_o(cmd_col_o), .cmd_page_o(cmd_page_o), .cmd_len_o(cmd_len_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .ecc_valid_o(ecc_valid_o), .ecc_code_o(ecc_code_o),
    .ecc_bad_i(ecc_bad_i)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int dval(input int a);
    return (a * 13 + (a >> 8) * 5 + 7) & 255;
  endfunction
  function automatic int sval(input int p, input int i);
    return (p * 16 + i * 3 + 81) & 255;
  endfunction

  // expected address walk
  int w_page, w_half, w_col, w_rem, w_phase, w_chunk, w_n, fail_chunk;
  bit run_big, run_ecc;
  int exp_mem[1024];
  int exp_wr = 0, exp_rd = 0;
  // device model
  int m_left = 0, m_k = 0, m_op = 0, m_col = 0, m_page = 0, tick = 0;
  bit st_pend = 0;
  int st_op, st_col, st_page, st_len;

  task automatic walk_adv();
    w_rem -= w_n;
    w_col = 0;
    if (!run_big) w_page++;
    else begin
      if (w_half == 1) w_page++;
      w_half ^= 1;
    end
    w_chunk++;
    w_phase = (w_rem == 0) ? 4 : 0;
  endtask

  task automatic on_cmd(input int op, input int col, input int page, input int len);
    case (w_phase)
      0: begin
        w_n = (256 - w_col < w_rem) ? 256 - w_col : w_rem;
        chk(page == w_page, (w_chunk == 0) ? "R2" : "R5", "data cmd page", page, w_page);
        chk(op == (run_big ? w_half : 0), "R3", "data cmd op", op, run_big ? w_half : 0);
        chk(col == (run_ecc ? 0 : w_col), (w_chunk == 0) ? "R3" : "R4", "data cmd column", col,
            run_ecc ? 0 : w_col);
        chk(len == (run_ecc ? 256 : w_n), "R6", "data cmd length", len, run_ecc ? 256 : w_n);
        for (int k = 0; k < w_n; k++) begin
          exp_mem[exp_wr] = dval(w_page * (run_big ? 512 : 256) + w_half * 256 + w_col + k);
          exp_wr++;
        end
        if (run_ecc) w_phase = 1;
        else walk_adv();
      end
      1: begin
        chk(op == 2 && col == w_half * 3 && len == 3 && page == w_page, "R7", "spare cmd column",
            col, w_half * 3);
        w_phase = 2;
      end
      2: begin
        chk(op == 0 && col == 0 && len == 0 && page == w_page, "R7", "restore cmd op", op, 0);
        w_phase = 3;
      end
      default: chk(1'b0, "R9", "unexpected command op", op, -1);
    endcase
  endtask

  initial begin
    forever begin
      @(negedge clk);
      tick++;
      if (!rst_ni) continue;
      if (out_valid_o) begin
        if (exp_rd < exp_wr) begin
          chk(out_data_o == exp_mem[exp_rd][7:0], "R6", "stream byte", out_data_o, exp_mem[exp_rd]);
          exp_rd++;
        end else chk(1'b0, "R6", "surplus byte", out_data_o, -1);
      end
      ecc_bad_i = 1'b0;
      if (ecc_valid_o) begin
        int e;
        e = (sval(w_page, w_half * 3) << 16) | (sval(w_page, w_half * 3 + 1) << 8)
            | sval(w_page, w_half * 3 + 2);
        chk(w_phase == 3 && ecc_code_o == 24'(e), "R7", "stored check bytes", ecc_code_o, e);
        if (w_chunk == fail_chunk) begin
          ecc_bad_i = 1'b1;
          w_phase = 4;
        end else walk_adv();
      end
      if (st_pend)
        chk(cmd_valid_o && cmd_op_o == 2'(st_op) && cmd_col_o == 8'(st_col)
            && cmd_page_o == PAGE_W'(st_page) && cmd_len_o == 9'(st_len),
            "R12", "stalled cmd column", cmd_col_o, st_col);
      rd_valid_i = 1'b0;
      if (m_left > 0 && (tick % 5) != 4) begin
        rd_valid_i = 1'b1;
        if (m_op == 2) rd_data_i = 8'(sval(m_page, m_col + m_k));
        else rd_data_i = 8'(dval(m_page * (run_big ? 512 : 256) + (m_op == 1 ? 256 : 0) + m_col + m_k));
        m_k++;
        m_left--;
      end
      cmd_ready_i = (tick % 3) != 1;
      st_pend = 0;
      if (cmd_valid_o) begin
        chk(ce_o, "R10", "select during cmd", ce_o, 1);
        if (cmd_ready_i) begin
          on_cmd(cmd_op_o, cmd_col_o, cmd_page_o, cmd_len_o);
          m_op = cmd_op_o; m_col = cmd_col_o; m_page = cmd_page_o;
          m_left = cmd_len_o; m_k = 0;
        end else begin
          st_pend = 1;
          st_op = cmd_op_o; st_col = cmd_col_o; st_page = cmd_page_o; st_len = cmd_len_o;
        end
      end
    end
  end

  task automatic run(input int addr, input int len, input bit big, input bit ecc, input int fail,
                     input bit exp_err, input bit inject, input string req);
    int psz, cyc;
    psz = big ? 512 : 256;
    cyc = 0;
    w_page = addr / psz;
    w_col = addr % psz;
    w_half = 0;
    if (w_col >= 256) begin w_half = 1; w_col -= 256; end
    w_rem = len; w_chunk = 0; fail_chunk = fail;
    run_big = big; run_ecc = ecc; exp_wr = 0; exp_rd = 0;
    w_phase = (addr + len > DEV || len == 0) ? 4 : 0;
    addr_i = ADDR_W'(addr); len_i = LEN_W'(len);
    big_page_i = big; ecc_mode_i = ecc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) begin
      cyc++;
      if (inject && cyc == 12) begin
        start_i = 1'b1; addr_i = '0; len_i = LEN_W'(1);
        big_page_i = ~big; ecc_mode_i = ~ecc;
      end else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(err_o == exp_err, req, "error flag at done", err_o, exp_err);
    chk(!ce_o, "R10", "select released at done", ce_o, 0);
    chk(exp_rd == exp_wr, inject ? "R11" : "R6", "bytes delivered", exp_rd, exp_wr);
    chk(w_phase == 4, inject ? "R11" : "R9", "command walk complete", w_phase, 4);
  endtask

  int addrs[6] = '{0, 3, 255, 256, 300, 511};
  int lens[5]  = '{1, 37, 256, 300, 700};

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o, "R9", "idle after reset", busy_o, 0);
    chk(!ce_o && !cmd_valid_o, "R10", "deselected after reset", ce_o, 0);
    chk(!out_valid_o && !ecc_valid_o, "R10", "no output after reset", out_valid_o, 0);
    // R1 range rejects and exact-end accept
    run(4000, 200, 0, 0, -1, 1, 0, "R1");
    run(4095, 2, 1, 1, -1, 1, 0, "R1");
    run(3796, 300, 1, 0, -1, 0, 0, "R1");
    run(3796, 301, 1, 0, -1, 1, 0, "R1");
    run(4095, 1, 0, 1, -1, 0, 0, "R1");
    // R9 zero length
    run(0, 0, 0, 0, -1, 0, 0, "R9");
    // sweep both page sizes, both modes, start columns and lengths
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < 2; e++)
        for (int ai = 0; ai < 6; ai++)
          for (int li = 0; li < 5; li++)
            run(addrs[ai], lens[li], b[0], e[0], -1, 0, 0, "R6");
    // R8 aborts
    run(300, 700, 1, 1, 1, 1, 0, "R8");
    run(5, 600, 0, 1, 0, 1, 0, "R8");
    run(256, 10, 1, 1, -1, 0, 0, "R7");
    // R11 start ignored while busy
    run(10, 700, 1, 1, -1, 0, 1, "R11");
    repeat (5) @(negedge clk);
    chk(!cmd_valid_o && !busy_o, "R8", "quiet after transfers", cmd_valid_o, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule